// File: doc/BRIEF.md
# Tagged FIFO with Interrupt Counter

This block is a 64-word first-in first-out queue whose entries carry 16 data bits and a one-bit interrupt tag. A receive-side frame sequencer pushes words while a message is arriving. A host side can also push words, with the tag given explicitly, and pops words through a simple strobe interface. Each host access is answered one cycle later by an acknowledge pulse and an accept bit.

Beside the queue, a saturating counter tracks how many stored entries carry the tag. A level interrupt request is raised while that counter is nonzero and interrupts are enabled. Software never clears the request. It falls only when the last tagged word has left the queue, or when software disables interrupts or overwrites the counter with zero. While a reception is in progress (`busy` high), every host access is refused.

Top module: `tagged_fifo_irq`

## Requirements
- R1: After reset the queue is empty, the tag count is 0 and interrupts are disabled, so `in_ready`=1, `out_ready`=0, `none_tagged`=1 and `irq`=0.
- R2: Words leave the queue in the order they entered. Bit 16 of a stored word is its tag and bits 15..0 are its data. A granted pop gives `rd_ack`=1, `rd_q`=1 and the word on `rd_data`/`rd_tag` in the cycle after the `host_rd` strobe.
- R3: A host read of an empty queue answers `rd_ack`=1 with `rd_q`=0 and changes no state.
- R4: The queue holds 64 words. A host write to a full queue answers `wr_q`=0 and stores nothing, and a sequencer push into a full queue is dropped.
- R5: Every accepted push with tag 1 increments the tag count and every pop of a tagged word decrements it. A tagged push and a tagged pop in the same cycle leave the count unchanged.
- R6: The tag count is 7 bits wide and saturates at 0 and at 127. A host count write loads its 8-bit value, and any value above 127 is clamped to 127. A count write wins over a push or pop in the same cycle.
- R7: `irq` is 1 exactly when the tag count is nonzero and interrupts are enabled. `host_irq_on` enables and `host_irq_off` disables, and disable wins if both are strobed together.
- R8: While `busy`=1, host reads, host writes, count writes and enable or disable commands have no effect and answer `rd_q`/`wr_q`=0. Sequencer pushes are still accepted.
- R9: A sequencer push takes priority over a host write in the same cycle. The host write is then refused with `wr_q`=0.
- R10: `none_tagged` is 1 when the count is 0, `in_ready` is 1 when the queue is not full, and `out_ready` is 1 when the queue is not empty. All three follow the registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Message reception in progress; host access refused |
| seq_push | input | 1 | Sequencer push strobe |
| seq_data | input | 16 | Sequencer data word |
| seq_tag | input | 1 | Sequencer interrupt tag |
| host_wr | input | 1 | Host write strobe |
| host_wr_data | input | 16 | Host write data |
| host_wr_tag | input | 1 | Host write tag |
| host_rd | input | 1 | Host read (pop) strobe |
| host_cnt_wr | input | 1 | Host tag-count overwrite strobe |
| host_cnt_val | input | 8 | Value for the count overwrite |
| host_irq_on | input | 1 | Enable interrupt request |
| host_irq_off | input | 1 | Disable interrupt request |
| rd_ack | output | 1 | Read response pulse |
| rd_q | output | 1 | Read granted (word valid) |
| rd_data | output | 16 | Popped data |
| rd_tag | output | 1 | Popped tag |
| wr_ack | output | 1 | Write response pulse |
| wr_q | output | 1 | Write accepted |
| tag_count | output | 8 | Tagged entries in queue |
| irq | output | 1 | Level interrupt request |
| none_tagged | output | 1 | Tag count is zero |
| in_ready | output | 1 | Queue not full |
| out_ready | output | 1 | Queue not empty |

## Verification
The assertions check every cycle that `irq` never stands with a zero count, that the count moves by at most one step without a host overwrite, that it stays within 127, that `none_tagged` agrees with the count, and that no grant appears while the queue was full, empty or busy. Word ordering, the exact count after simultaneous tagged push and pop, clamping of overwrite values, and the moment `irq` falls after the last tagged pop are shown only by the bench. The bench compares every response against a reference queue it keeps itself.

// File: rtl/tq_pkg.sv
package tq_pkg;
  localparam int DATA_W_DEF = 16;
  localparam int DEPTH_DEF  = 64;
  localparam int CNT_W_DEF  = 7;
  localparam int LOAD_W_DEF = 8;

  typedef enum logic [1:0] {
    CS_HOLD = 2'd0,
    CS_UP   = 2'd1,
    CS_DOWN = 2'd2,
    CS_LOAD = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/tq_ptrs.sv
module tq_ptrs #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          full,
  output logic          empty
);
  logic [LW-1:0] level;

  always_ff @(posedge clk) begin
    if (rst) begin
      waddr <= '0;
      raddr <= '0;
      level <= '0;
    end else begin
      if (push) waddr <= waddr + AW'(1);
      if (pop)  raddr <= raddr + AW'(1);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
endmodule

// File: rtl/tq_store.sv
module tq_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int EW = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [EW-1:0]     wword,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [EW-1:0]     rword,
  output logic              head_tag
);
  logic [EW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] tag_shadow;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wword;
  end

  always_ff @(posedge clk) begin
    if (rst)     rword <= '0;
    else if (re) rword <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst)     tag_shadow <= '0;
    else if (we) tag_shadow[waddr] <= wword[EW-1];
  end

  assign head_tag = tag_shadow[raddr];
endmodule

// File: rtl/tq_tagcnt.sv
module tq_tagcnt
  import tq_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int LOAD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              dec,
  input  logic              load,
  input  logic [LOAD_W-1:0] load_val,
  input  logic              en_set,
  input  logic              en_clr,
  output logic [CNT_W-1:0]  count,
  output logic              irq,
  output logic              none
);
  localparam logic [CNT_W-1:0]  CMAX  = {CNT_W{1'b1}};
  localparam logic [LOAD_W-1:0] CMAXL = LOAD_W'(CMAX);

  cnt_op_e          op;
  logic [CNT_W-1:0] cnt_nx;
  logic             en_q, en_nx;

  always_comb begin
    if (load)            op = CS_LOAD;
    else if (inc && !dec) op = CS_UP;
    else if (dec && !inc) op = CS_DOWN;
    else                 op = CS_HOLD;
  end

  always_comb begin
    case (op)
      CS_LOAD: cnt_nx = (load_val > CMAXL) ? CMAX : load_val[CNT_W-1:0];
      CS_UP:   cnt_nx = (count == CMAX) ? count : count + CNT_W'(1);
      CS_DOWN: cnt_nx = (count == '0) ? count : count - CNT_W'(1);
      default: cnt_nx = count;
    endcase
  end

  always_comb begin
    if (en_clr)      en_nx = 1'b0;
    else if (en_set) en_nx = 1'b1;
    else             en_nx = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      en_q  <= 1'b0;
      irq   <= 1'b0;
      none  <= 1'b1;
    end else begin
      count <= cnt_nx;
      en_q  <= en_nx;
      irq   <= en_nx && (cnt_nx != '0);
      none  <= (cnt_nx == '0);
    end
  end
endmodule

// File: rtl/tagged_fifo_irq.sv
module tagged_fifo_irq
  import tq_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int DEPTH  = DEPTH_DEF,
  parameter int CNT_W  = CNT_W_DEF,
  parameter int LOAD_W = LOAD_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              seq_push,
  input  logic [DATA_W-1:0] seq_data,
  input  logic              seq_tag,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_wr_tag,
  input  logic              host_rd,
  input  logic              host_cnt_wr,
  input  logic [LOAD_W-1:0] host_cnt_val,
  input  logic              host_irq_on,
  input  logic              host_irq_off,
  output logic              rd_ack,
  output logic              rd_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic              wr_ack,
  output logic              wr_q,
  output logic [LOAD_W-1:0] tag_count,
  output logic              irq,
  output logic              none_tagged,
  output logic              in_ready,
  output logic              out_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DATA_W + 1;

  logic          host_ok, full, empty;
  logic          seq_go, host_go, push, pop, head_tag;
  logic [AW-1:0] waddr, raddr;
  logic [EW-1:0] wword, rword;
  logic [CNT_W-1:0] cnt;

  assign host_ok = !busy;
  assign seq_go  = seq_push && !full;
  assign host_go = host_wr && host_ok && !seq_push && !full;
  assign push    = seq_go || host_go;
  assign pop     = host_rd && host_ok && !empty;
  assign wword   = seq_push ? {seq_tag, seq_data} : {host_wr_tag, host_wr_data};

  tq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .waddr(waddr), .raddr(raddr), .full(full), .empty(empty)
  );

  tq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(push), .waddr(waddr), .wword(wword),
    .re(pop), .raddr(raddr), .rword(rword), .head_tag(head_tag)
  );

  tq_tagcnt #(.CNT_W(CNT_W), .LOAD_W(LOAD_W)) u_cnt (
    .clk(clk), .rst(rst),
    .inc(push && wword[EW-1]),
    .dec(pop && head_tag),
    .load(host_cnt_wr && host_ok),
    .load_val(host_cnt_val),
    .en_set(host_irq_on && host_ok),
    .en_clr(host_irq_off && host_ok),
    .count(cnt), .irq(irq), .none(none_tagged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack <= 1'b0;
      rd_q   <= 1'b0;
      wr_ack <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      rd_ack <= host_rd;
      rd_q   <= pop;
      wr_ack <= host_wr;
      wr_q   <= host_go;
    end
  end

  assign rd_data   = rword[DATA_W-1:0];
  assign rd_tag    = rword[EW-1];
  assign tag_count = LOAD_W'(cnt);
  assign in_ready  = !full;
  assign out_ready = !empty;
endmodule

// File: rtl/tq_checks.sv
module tq_checks #(
  parameter int LOAD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              host_cnt_wr,
  input logic              rd_ack,
  input logic              rd_q,
  input logic              wr_ack,
  input logic              wr_q,
  input logic [LOAD_W-1:0] tag_count,
  input logic              irq,
  input logic              none_tagged,
  input logic              in_ready,
  input logic              out_ready
);
  p_irq_needs_count_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (tag_count != '0));

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(host_cnt_wr) |->
      (({1'b0, tag_count} <= {1'b0, $past(tag_count)} + 1'b1) &&
       ({1'b0, tag_count} + 1'b1 >= {1'b0, $past(tag_count)})));

  p_count_limit_r6: assert property (@(posedge clk) disable iff (rst)
    tag_count <= LOAD_W'(127));

  p_none_flag_r10: assert property (@(posedge clk) disable iff (rst)
    none_tagged == (tag_count == '0));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    wr_q |-> $past(in_ready));

  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    rd_q |-> $past(out_ready));

  p_busy_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && $past(busy)) |-> !rd_q);

  p_busy_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_ack && $past(busy)) |-> !wr_q);
endmodule

bind tagged_fifo_irq tq_checks #(.LOAD_W(LOAD_W)) u_checks (
  .clk(clk), .rst(rst), .busy(busy), .host_cnt_wr(host_cnt_wr),
  .rd_ack(rd_ack), .rd_q(rd_q), .wr_ack(wr_ack), .wr_q(wr_q),
  .tag_count(tag_count), .irq(irq), .none_tagged(none_tagged),
  .in_ready(in_ready), .out_ready(out_ready)
);

// File: tb/tb_tagged_fifo_irq.sv
module tb_tagged_fifo_irq;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busy, seq_push, seq_tag, host_wr, host_wr_tag, host_rd;
  logic        host_cnt_wr, host_irq_on, host_irq_off;
  logic [15:0] seq_data, host_wr_data;
  logic [7:0]  host_cnt_val;
  logic        rd_ack, rd_q, rd_tag, wr_ack, wr_q;
  logic [15:0] rd_data;
  logic [7:0]  tag_count;
  logic        irq, none_tagged, in_ready, out_ready;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [16:0] mq[$];
  int          mcnt = 0;
  bit          men  = 1'b0;

  always #2.5 clk = ~clk;

  tagged_fifo_irq dut (
    .clk(clk), .rst(rst), .busy(busy),
    .seq_push(seq_push), .seq_data(seq_data), .seq_tag(seq_tag),
    .host_wr(host_wr), .host_wr_data(host_wr_data), .host_wr_tag(host_wr_tag),
    .host_rd(host_rd), .host_cnt_wr(host_cnt_wr), .host_cnt_val(host_cnt_val),
    .host_irq_on(host_irq_on), .host_irq_off(host_irq_off),
    .rd_ack(rd_ack), .rd_q(rd_q), .rd_data(rd_data), .rd_tag(rd_tag),
    .wr_ack(wr_ack), .wr_q(wr_q), .tag_count(tag_count), .irq(irq),
    .none_tagged(none_tagged), .in_ready(in_ready), .out_ready(out_ready)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    busy = 0; seq_push = 0; seq_tag = 0; seq_data = '0;
    host_wr = 0; host_wr_tag = 0; host_wr_data = '0; host_rd = 0;
    host_cnt_wr = 0; host_cnt_val = '0; host_irq_on = 0; host_irq_off = 0;
  endtask

  function automatic int sat(int v);
    if (v < 0) return 0;
    if (v > 127) return 127;
    return v;
  endfunction

  // One clock: reference model update, then compare all outputs.
  task automatic step();
    int          sz = mq.size();
    bit          hok, sw, hw, pp;
    logic [16:0] head, nw;
    int          nc;
    string       rreq, wreq;
    hok  = !busy;
    sw   = seq_push && (sz < DEPTH);
    hw   = host_wr && hok && !seq_push && (sz < DEPTH);
    pp   = host_rd && hok && (sz > 0);
    head = pp ? mq[0] : 17'd0;
    nw   = seq_push ? {seq_tag, seq_data} : {host_wr_tag, host_wr_data};
    if (host_cnt_wr && hok) nc = (host_cnt_val > 127) ? 127 : int'(host_cnt_val);
    else begin
      nc = mcnt;
      if ((sw || hw) && nw[16]) nc++;
      if (pp && head[16]) nc--;
      nc = sat(nc);
    end
    if (pp) void'(mq.pop_front());
    if (sw || hw) mq.push_back(nw);
    mcnt = nc;
    if (hok) begin
      if (host_irq_off) men = 1'b0;
      else if (host_irq_on) men = 1'b1;
    end
    rreq = busy ? "R8" : ((sz == 0) ? "R3" : "R2");
    wreq = busy ? "R8" : (seq_push ? "R9" : ((sz >= DEPTH) ? "R4" : "R2"));
    @(posedge clk);
    @(negedge clk);
    chk(rreq, "rd_ack", int'(rd_ack), int'(host_rd));
    chk(rreq, "rd_q", int'(rd_q), int'(pp));
    if (pp) begin
      chk("R2", "rd_data", int'(rd_data), int'(head[15:0]));
      chk("R2", "rd_tag", int'(rd_tag), int'(head[16]));
    end
    chk(wreq, "wr_ack", int'(wr_ack), int'(host_wr));
    chk(wreq, "wr_q", int'(wr_q), int'(hw));
    chk(host_cnt_wr ? "R6" : "R5", "tag_count", int'(tag_count), mcnt);
    chk("R7", "irq", int'(irq), int'(men && mcnt != 0));
    chk("R10", "none_tagged", int'(none_tagged), int'(mcnt == 0));
    chk("R10", "in_ready", int'(in_ready), int'(mq.size() < DEPTH));
    chk("R10", "out_ready", int'(out_ready), int'(mq.size() > 0));
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clr();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "in_ready", int'(in_ready), 1);
    chk("R1", "out_ready", int'(out_ready), 0);
    chk("R1", "none_tagged", int'(none_tagged), 1);
    chk("R1", "tag_count", int'(tag_count), 0);
    chk("R1", "irq", int'(irq), 0);

    // R3 read of empty queue
    clr(); host_rd = 1; step();

    // R7 enable, then fill to full with alternating tags (R2, R5)
    clr(); host_irq_on = 1; step();
    for (int i = 0; i < DEPTH; i++) begin
      clr(); host_wr = 1; host_wr_data = 16'(i * 37 + 5); host_wr_tag = i[0]; step();
    end
    chk("R4", "count_full", int'(tag_count), 32);
    // R4 write and sequencer push into full queue
    clr(); host_wr = 1; host_wr_data = 16'hBEEF; host_wr_tag = 1; step();
    clr(); seq_push = 1; busy = 1; seq_data = 16'hCAFE; seq_tag = 1; step();
    // R8 host read refused while busy
    clr(); busy = 1; host_rd = 1; step();
    clr(); busy = 1; host_irq_off = 1; step();
    chk("R8", "irq_kept", int'(irq), 1);
    // R5 simultaneous tagged pop and tagged push (pop first makes room next)
    clr(); host_rd = 1; step();
    clr(); host_rd = 1; host_wr = 1; host_wr_tag = 1; host_wr_data = 16'h1234; step();
    // R9 sequencer wins over host write
    clr(); host_rd = 1; step();
    clr(); seq_push = 1; seq_data = 16'h5A5A; seq_tag = 0; host_wr = 1; host_wr_tag = 1; step();
    // R6 count overwrite clamped, and ignored while busy
    clr(); host_cnt_wr = 1; host_cnt_val = 8'd200; step();
    chk("R6", "clamp", int'(tag_count), 127);
    clr(); busy = 1; host_cnt_wr = 1; host_cnt_val = 8'd3; step();
    chk("R8", "cnt_busy", int'(tag_count), 127);
    clr(); host_cnt_wr = 1; host_cnt_val = 8'd0; step();
    // drain; tagged pops at zero count must stay at 0 (R6)
    while (mq.size() > 0) begin clr(); host_rd = 1; step(); end
    chk("R6", "floor", int'(tag_count), 0);

    // R7 irq falls exactly when the last tagged word leaves
    clr(); host_wr = 1; host_wr_tag = 1; host_wr_data = 16'h0001; step();
    clr(); host_wr = 1; host_wr_tag = 0; host_wr_data = 16'h0002; step();
    chk("R7", "irq_up", int'(irq), 1);
    clr(); host_rd = 1; step();
    chk("R7", "irq_drop", int'(irq), 0);
    clr(); host_rd = 1; step();
    // R7 disable wins over enable
    clr(); host_irq_on = 1; host_irq_off = 1; step();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      clr();
      busy         = ($urandom % 6) == 0;
      seq_push     = busy ? (($urandom % 2) == 0) : (($urandom % 10) == 0);
      seq_data     = 16'($urandom);
      seq_tag      = 1'($urandom);
      host_wr      = ($urandom % 100) < ((i % 800 < 400) ? 60 : 30);
      host_wr_data = 16'($urandom);
      host_wr_tag  = 1'($urandom);
      host_rd      = ($urandom % 100) < ((i % 800 < 400) ? 25 : 65);
      host_cnt_wr  = ($urandom % 60) == 0;
      host_cnt_val = 8'($urandom);
      host_irq_on  = ($urandom % 15) == 0;
      host_irq_off = ($urandom % 25) == 0;
      step();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule